// File: doc/BRIEF.md
# PCI Target Exclusive-Access Lock Tracker

This block lives inside a PCI target and decides, for every transaction that decodes to the target, whether the transaction is served normally or refused with a retry. It watches the active-low bus controls each clock: FRAME#, LOCK#, IRDY#, TRDY#, plus an address-phase strobe and the target's own address hit. From these it learns when a master takes exclusive ownership of the target and when that ownership ends. The reservation covers this target only, so traffic to other targets is never affected.

A master claims the target with a transaction that starts with LOCK# high in the address phase, drives LOCK# low on the next clock, and completes at least one data phase. From then on, an address phase that hits the target with LOCK# high comes from the owner and is served. An address phase that hits it with LOCK# low comes from a different master and gets a retry: STOP# and DEVSEL# are driven and data transfer is inhibited. The reservation ends on the first clock where FRAME# and LOCK# are both sampled high.

Top module: `pci_excl_lock_tracker`

## Requirements
- R1: While locked, an address phase with `hit` high and `lock_n` high is served. In the next cycle `serve_o` is 1, `retry_pulse_o` is 0 and `stop_n_o` is 1.
- R2: While locked, an address phase with `hit` high and `lock_n` low is refused. In the next cycle `retry_pulse_o` is 1 and `serve_o` is 0.
- R3: A refused access is answered from the cycle after its address phase until the cycle after the bus is sampled idle (`frame_n` and `irdy_n` both 1). During that span `stop_n_o` and `devsel_n_o` are 0 and `xfer_inhibit_o` is 1.
- R4: While locked, a clock that samples `frame_n` = 1 and `lock_n` = 1 makes `locked_o` 0 in the next cycle.
- R5: While locked, the lock is kept on every clock where `frame_n` or `lock_n` is low. This includes the owner's own accesses and idle gaps in which LOCK# stays low.
- R6: The target becomes locked when all of the following hold: a hit address phase with `lock_n` high, `lock_n` low on the following clock, and a clock in that transaction with `irdy_n` and `trdy_n` both 0. `locked_o` rises in the cycle after that data clock. This also holds when FRAME# is already high in that data clock (single data phase).
- R7: No lock is taken if LOCK# is not low on the clock after the address phase. No lock is taken if the transaction reaches bus idle without a data phase.
- R8: While unlocked, a hit address phase with `lock_n` low is served normally and no retry is issued.
- R9: An address phase with `hit` low produces neither service nor retry and does not change `locked_o`.
- R10: An asynchronous low `rst_n` clears `locked_o`, `serve_o`, `xfer_inhibit_o` and `retry_pulse_o`, and drives `stop_n_o` and `devsel_n_o` to 1.
- R11: `retry_pulse_o` is high for exactly one cycle per refused access.
- R12: `serve_o` stays high from the cycle after a served address phase until the cycle after bus idle is sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low reset, asynchronous assert |
| frame_n | input | 1 | Sampled FRAME#, low active |
| lock_n | input | 1 | Sampled LOCK#, low active |
| irdy_n | input | 1 | Sampled IRDY#, low active |
| trdy_n | input | 1 | Sampled TRDY#, low active |
| addr_phase | input | 1 | High in the clock that carries an address |
| hit | input | 1 | Address decodes to this target (valid with `addr_phase`) |
| locked_o | output | 1 | Target is reserved by a master |
| serve_o | output | 1 | Current access is to be served normally |
| stop_n_o | output | 1 | STOP# request to the response logic, low active |
| devsel_n_o | output | 1 | DEVSEL# request for a refused access, low active |
| xfer_inhibit_o | output | 1 | Block TRDY#, no data moves |
| retry_pulse_o | output | 1 | One-cycle marker of a refused access |

## Verification
Two functions can fall in the same clock: lock establishment and the end of the locking transaction. They coincide when the only data phase happens with FRAME# already high, so the data handshake and the last-phase marker share one clock. The bench provokes this with a single-phase locking access. It then checks that `locked_o` rises and survives the following bus-idle clocks, during which LOCK# stays low. It also checks that a later non-owner hit is refused. A second coincidence is tested as well: the owner releases LOCK# on the clock right after the data phase that established the lock. In that case `locked_o` must pulse high for exactly one cycle.

// File: rtl/lk_pkg.sv
package lk_pkg;

  // Reservation state of the target
  typedef enum logic [1:0] {
    LK_FREE  = 2'd0,  // no reservation
    LK_PEND  = 2'd1,  // candidate address phase seen, lock line not yet checked
    LK_ARMED = 2'd2,  // lock line seen low, waiting for a data handshake
    LK_HELD  = 2'd3   // reserved by one master
  } lk_state_e;

  // Response chosen for the current access
  typedef enum logic [1:0] {
    RSP_NONE  = 2'd0,
    RSP_SERVE = 2'd1,
    RSP_RETRY = 2'd2
  } lk_resp_e;

endpackage

// File: rtl/lk_bus_decode.sv
module lk_bus_decode (
  input  logic frame_n,
  input  logic lock_n,
  input  logic irdy_n,
  input  logic trdy_n,
  input  logic addr_phase,
  input  logic hit,
  output logic addr_hit,
  output logic lock_on,
  output logic data_xfer,
  output logic bus_idle,
  output logic release_ok
);

  always_comb begin
    addr_hit   = addr_phase & hit;
    lock_on    = ~lock_n;
    data_xfer  = ~irdy_n & ~trdy_n;
    bus_idle   = frame_n & irdy_n;
    release_ok = frame_n & lock_n;
  end

endmodule

// File: rtl/lk_lock_fsm.sv
module lk_lock_fsm
  import lk_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      addr_hit,
  input  logic      lock_on,
  input  logic      data_xfer,
  input  logic      bus_idle,
  input  logic      release_ok,
  output lk_state_e state_q,
  output logic      held
);

  lk_state_e state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      LK_FREE: begin
        if (addr_hit && !lock_on) state_d = LK_PEND;
      end
      LK_PEND: begin
        if (!lock_on)       state_d = LK_FREE;
        else if (data_xfer) state_d = LK_HELD;
        else if (bus_idle)  state_d = LK_FREE;
        else                state_d = LK_ARMED;
      end
      LK_ARMED: begin
        if (data_xfer)     state_d = LK_HELD;
        else if (bus_idle) state_d = LK_FREE;
      end
      LK_HELD: begin
        if (release_ok) state_d = LK_FREE;
      end
      default: state_d = LK_FREE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= LK_FREE;
    else        state_q <= state_d;
  end

  assign held = (state_q == LK_HELD);

endmodule

// File: rtl/lk_resp_ctrl.sv
module lk_resp_ctrl
  import lk_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     addr_hit,
  input  logic     lock_on,
  input  logic     bus_idle,
  input  logic     held,
  output lk_resp_e resp_q,
  output logic     pulse_q
);

  lk_resp_e resp_d;
  logic     refuse;
  logic     resp_en;

  assign refuse  = addr_hit & held & lock_on;
  assign resp_en = addr_hit | bus_idle;

  always_comb begin
    resp_d = resp_q;
    if (addr_hit)      resp_d = refuse ? RSP_RETRY : RSP_SERVE;
    else if (bus_idle) resp_d = RSP_NONE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       resp_q <= RSP_NONE;
    else if (resp_en) resp_q <= resp_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pulse_q <= 1'b0;
    else        pulse_q <= refuse;
  end

endmodule

// File: rtl/pci_excl_lock_tracker.sv
module pci_excl_lock_tracker
  import lk_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic frame_n,
  input  logic lock_n,
  input  logic irdy_n,
  input  logic trdy_n,
  input  logic addr_phase,
  input  logic hit,
  output logic locked_o,
  output logic serve_o,
  output logic stop_n_o,
  output logic devsel_n_o,
  output logic xfer_inhibit_o,
  output logic retry_pulse_o
);

  logic      addr_hit, lock_on, data_xfer, bus_idle, release_ok;
  logic      held;
  lk_state_e state_q;
  lk_resp_e  resp_q;
  logic      pulse_q;

  lk_bus_decode u_dec (
    .frame_n    (frame_n),
    .lock_n     (lock_n),
    .irdy_n     (irdy_n),
    .trdy_n     (trdy_n),
    .addr_phase (addr_phase),
    .hit        (hit),
    .addr_hit   (addr_hit),
    .lock_on    (lock_on),
    .data_xfer  (data_xfer),
    .bus_idle   (bus_idle),
    .release_ok (release_ok)
  );

  lk_lock_fsm u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .addr_hit   (addr_hit),
    .lock_on    (lock_on),
    .data_xfer  (data_xfer),
    .bus_idle   (bus_idle),
    .release_ok (release_ok),
    .state_q    (state_q),
    .held       (held)
  );

  lk_resp_ctrl u_rsp (
    .clk      (clk),
    .rst_n    (rst_n),
    .addr_hit (addr_hit),
    .lock_on  (lock_on),
    .bus_idle (bus_idle),
    .held     (held),
    .resp_q   (resp_q),
    .pulse_q  (pulse_q)
  );

  assign locked_o       = held;
  assign serve_o        = (resp_q == RSP_SERVE);
  assign xfer_inhibit_o = (resp_q == RSP_RETRY);
  assign stop_n_o       = ~xfer_inhibit_o;
  assign devsel_n_o     = ~xfer_inhibit_o;
  assign retry_pulse_o  = pulse_q;

endmodule

// File: rtl/lk_checker.sv
module lk_checker (
  input logic clk,
  input logic rst_n,
  input logic frame_n,
  input logic lock_n,
  input logic irdy_n,
  input logic trdy_n,
  input logic addr_phase,
  input logic hit,
  input logic locked_o,
  input logic serve_o,
  input logic stop_n_o,
  input logic devsel_n_o,
  input logic xfer_inhibit_o,
  input logic retry_pulse_o
);

  p_owner_served_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (locked_o && addr_phase && hit && lock_n) |=> (serve_o && !retry_pulse_o && stop_n_o));

  p_other_refused_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (locked_o && addr_phase && hit && !lock_n) |=> (retry_pulse_o && !serve_o));

  p_refuse_drives_r3: assert property (@(posedge clk) disable iff (!rst_n)
    retry_pulse_o |-> (!stop_n_o && !devsel_n_o && xfer_inhibit_o));

  p_release_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (locked_o && frame_n && lock_n) |=> !locked_o);

  p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (locked_o && !(frame_n && lock_n)) |=> locked_o);

  p_needs_data_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(locked_o) |-> $past(!irdy_n && !trdy_n && !lock_n));

  p_free_no_retry_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!locked_o && addr_phase && hit) |=> (serve_o && !retry_pulse_o));

  p_miss_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_phase && !hit) |=> !retry_pulse_o);

  p_single_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
    retry_pulse_o |=> !retry_pulse_o);

  always @(posedge clk) begin
    if (!rst_n) begin
      p_reset_r10: assert (!locked_o && !serve_o && stop_n_o && devsel_n_o && !retry_pulse_o);
    end
  end

endmodule

bind pci_excl_lock_tracker lk_checker u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .frame_n        (frame_n),
  .lock_n         (lock_n),
  .irdy_n         (irdy_n),
  .trdy_n         (trdy_n),
  .addr_phase     (addr_phase),
  .hit            (hit),
  .locked_o       (locked_o),
  .serve_o        (serve_o),
  .stop_n_o       (stop_n_o),
  .devsel_n_o     (devsel_n_o),
  .xfer_inhibit_o (xfer_inhibit_o),
  .retry_pulse_o  (retry_pulse_o)
);

// File: tb/sim_pci_excl_lock_tracker.sv
module sim_pci_excl_lock_tracker;

  localparam int CLK_PERIOD = 10;

  logic clk, rst_n;
  logic frame_n, lock_n, irdy_n, trdy_n, addr_phase, hit;
  logic locked_o, serve_o, stop_n_o, devsel_n_o, xfer_inhibit_o, retry_pulse_o;

  pci_excl_lock_tracker u0 (
    .clk(clk), .rst_n(rst_n), .frame_n(frame_n), .lock_n(lock_n),
    .irdy_n(irdy_n), .trdy_n(trdy_n), .addr_phase(addr_phase), .hit(hit),
    .locked_o(locked_o), .serve_o(serve_o), .stop_n_o(stop_n_o),
    .devsel_n_o(devsel_n_o), .xfer_inhibit_o(xfer_inhibit_o),
    .retry_pulse_o(retry_pulse_o)
  );

  typedef struct {
    logic  lk;
    logic  sv;
    logic  rt;
    logic  pl;
    string tag;
  } exp_t;

  exp_t exp_q[$];
  int   n_cmp = 0;
  int   n_bad = 0;
  bit   done  = 0;

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input logic act, input logic exp, input string what, input string tag);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %b expected %b at %0t", tag, what, act, exp, $time);
    end
  endtask

  // monitor: compares after each rising edge, away from the edge
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (exp_q.size() > 0) begin
        exp_t e;
        e = exp_q.pop_front();
        chk(locked_o,       e.lk,  "locked_o",       e.tag);
        chk(serve_o,        e.sv,  "serve_o",        e.tag);
        chk(stop_n_o,       ~e.rt, "stop_n_o",       e.tag);
        chk(devsel_n_o,     ~e.rt, "devsel_n_o",     e.tag);
        chk(xfer_inhibit_o, e.rt,  "xfer_inhibit_o", e.tag);
        chk(retry_pulse_o,  e.pl,  "retry_pulse_o",  e.tag);
      end
    end
  end

  // driver: one bus clock of inputs and the outputs expected after its edge
  task automatic cyc(input logic f, input logic l, input logic i, input logic t,
                     input logic ap, input logic h,
                     input logic elk, input logic esv, input logic ert, input logic epl,
                     input string tag);
    exp_t e;
    @(negedge clk);
    frame_n = f; lock_n = l; irdy_n = i; trdy_n = t; addr_phase = ap; hit = h;
    e.lk = elk; e.sv = esv; e.rt = ert; e.pl = epl; e.tag = tag;
    exp_q.push_back(e);
  endtask

  task automatic idle(input logic l, input logic elk, input string tag);
    cyc(1, l, 1, 1, 0, 0, elk, 0, 0, 0, tag);
  endtask

  initial begin
    frame_n = 1; lock_n = 1; irdy_n = 1; trdy_n = 1; addr_phase = 0; hit = 0;
    rst_n = 0;
    idle(1, 0, "R10");
    idle(1, 0, "R10");
    @(negedge clk); rst_n = 1;
    idle(1, 0, "R10");

    // unlocked access with LOCK# low is served (R8)
    cyc(0, 0, 1, 1, 1, 1, 0, 1, 0, 0, "R8");
    cyc(1, 0, 0, 0, 0, 0, 0, 1, 0, 0, "R12");
    idle(1, 0, "R12");
    // miss address phase (R9)
    cyc(0, 0, 1, 1, 1, 0, 0, 0, 0, 0, "R9");
    idle(1, 0, "R9");

    // LOCK# not low after address: no lock (R7)
    cyc(0, 1, 1, 1, 1, 1, 0, 1, 0, 0, "R7");
    cyc(0, 1, 0, 0, 0, 0, 0, 1, 0, 0, "R7");
    cyc(1, 1, 0, 0, 0, 0, 0, 1, 0, 0, "R7");
    idle(1, 0, "R7");
    // ends without data: no lock (R7)
    cyc(0, 1, 1, 1, 1, 1, 0, 1, 0, 0, "R7");
    cyc(0, 0, 0, 1, 0, 0, 0, 1, 0, 0, "R7");
    cyc(1, 0, 0, 1, 0, 0, 0, 1, 0, 0, "R7");
    idle(1, 0, "R7");
    idle(1, 0, "R7");

    // single-phase locking access: lock set as transaction ends (R6)
    cyc(0, 1, 1, 1, 1, 1, 0, 1, 0, 0, "R6");
    cyc(1, 0, 0, 0, 0, 0, 1, 1, 0, 0, "R6");
    idle(0, 1, "R5");
    idle(0, 1, "R5");

    // other master hits the locked target (R2, R3, R11)
    cyc(0, 0, 1, 1, 1, 1, 1, 0, 1, 1, "R2");
    cyc(1, 0, 0, 1, 0, 0, 1, 0, 1, 0, "R11");
    cyc(1, 0, 1, 1, 0, 0, 1, 0, 0, 0, "R3");
    // miss while locked (R9)
    cyc(0, 0, 1, 1, 1, 0, 1, 0, 0, 0, "R9");
    cyc(1, 0, 0, 0, 0, 0, 1, 0, 0, 0, "R9");
    idle(0, 1, "R9");

    // owner comes back (R1, R5)
    cyc(0, 1, 1, 1, 1, 1, 1, 1, 0, 0, "R1");
    cyc(0, 0, 0, 0, 0, 0, 1, 1, 0, 0, "R5");
    cyc(1, 0, 0, 0, 0, 0, 1, 1, 0, 0, "R12");
    idle(0, 1, "R12");
    // release (R4)
    idle(1, 0, "R4");
    // after release LOCK# low is ordinary (R8)
    cyc(0, 0, 1, 1, 1, 1, 0, 1, 0, 0, "R8");
    cyc(1, 0, 0, 0, 0, 0, 0, 1, 0, 0, "R8");
    idle(1, 0, "R8");

    // multi-phase establishment, release right after the data clock (R6, R4)
    cyc(0, 1, 1, 1, 1, 1, 0, 1, 0, 0, "R6");
    cyc(0, 0, 0, 1, 0, 0, 0, 1, 0, 0, "R6");
    cyc(1, 0, 0, 0, 0, 0, 1, 1, 0, 0, "R6");
    idle(1, 0, "R4");

    // lock again, then asynchronous reset (R10)
    cyc(0, 1, 1, 1, 1, 1, 0, 1, 0, 0, "R6");
    cyc(0, 0, 0, 0, 0, 0, 1, 1, 0, 0, "R6");
    cyc(0, 0, 1, 1, 1, 1, 1, 0, 1, 1, "R2");
    @(negedge clk); rst_n = 0;
    idle(0, 0, "R10");
    @(negedge clk); rst_n = 1;
    idle(1, 0, "R10");

    repeat (4) @(negedge clk);
    done = 1;
  end

  initial begin
    fork
      begin wait (done); end
      begin
        repeat (5000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule